// File: doc/BRIEF.md
# Memory-space base address register

This block is a single 32-bit configuration register that gives a memory-mapped bus target a window whose location the host chooses at enumeration time. The host sizes the window by writing all ones and then reading the register back. Address bits below the window size are hardwired to zero, so the value read back is a size mask. The host then writes the real base address. Only the upper bits, at and above the window size, store what the host writes.

The low four bits never change. Bit 0 is zero to mark memory space. Bits 2:1 are zero to mark a 32-bit decode. Bit 3 is the prefetchable flag, set by a parameter. A combinational hit output compares the upper bits of the bus address with the stored base while address decode is enabled.

Parameter `SZ` is the log2 of the window size in bytes. It must be greater than 4, and its default of 16 gives a 64 KiB window. Parameter `PREFETCH` sets bit 3.

Top module: `pci_mem_bar`

## Requirements
- R1: After reset the writable bits (31:SZ) are zero, and the first configuration read returns only the type nibble: 0x00000008 with the default parameters.
- R2: Read data bits 3:0 always equal {PREFETCH, 3'b000}, whatever was written.
- R3: Read data bits SZ-1:4 always read zero. After a write of 0xFFFFFFFF with all byte enables set, a read returns 0xFFFF0008 with the default parameters.
- R4: On a cycle with cfg_wr high, each register bit at or above SZ whose byte lane enable is set takes the matching bit of cfg_wdata. Enable bit k covers data bits 8k+7:8k.
- R5: During a write, register bits in a byte lane whose enable is clear keep their value.
- R6: cfg_rdata is registered. It shows the register value one clock after a cycle with cfg_rd high, and it holds its value when cfg_rd is low.
- R7: In the same cycle, hit is high when dec_en is high and bus_addr[31:SZ] equals the stored base. Otherwise hit is low.
- R8: hit is low whenever dec_en is low, whatever the bus address.
- R9: When cfg_rd and cfg_wr are both high in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte lane enables for the write |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_rdata | output | 32 | Registered read data |
| bus_addr | input | 32 | Bus address to decode |
| dec_en | input | 1 | Memory decode enable |
| hit | output | 1 | Bus address falls in the assigned window |

## Verification
A wrong stored base shows up at once on hit. It shows on the read port one clock after the next read. A wrong byte-lane mask appears as a mismatch in a single byte of the upper half on the following read. A leaking low bit or type bit appears in the first read after any write. Because the bench compares both outputs on every clock against its own model, any divergence is reported in the cycle where it first reaches a port.

// File: rtl/pci_mem_bar.sv
module pci_mem_bar #(
  parameter int SZ       = 16,
  parameter bit PREFETCH = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  input  logic        cfg_rd,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] bus_addr,
  input  logic        dec_en,
  output logic        hit
);
  localparam int         BW   = 32 - SZ;
  localparam logic [3:0] TYPE = {PREFETCH, 3'b000};

  logic [BW-1:0] base_q;
  logic [31:0]   lane_m, cur, nxt;
  logic          unused_bits;

  assign lane_m = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
  assign cur    = {base_q, {SZ{1'b0}}};
  assign nxt    = (cur & ~lane_m) | (cfg_wdata & lane_m);
  assign hit    = dec_en && (bus_addr[31:SZ] == base_q);

  assign unused_bits = ^{bus_addr[SZ-1:0], nxt[SZ-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      cfg_rdata <= {28'd0, TYPE};
    end else begin
      if (cfg_rd) cfg_rdata <= cur | {28'd0, TYPE};
      if (cfg_wr) base_q    <= nxt[31:SZ];
    end
  end
endmodule

module pci_mem_bar_props #(
  parameter int SZ       = 16,
  parameter bit PREFETCH = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_rd,
  input logic [31:0] cfg_rdata,
  input logic        dec_en,
  input logic        hit
);
  AST_TYPE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:0] == {PREFETCH, 3'b000}); // R2
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[SZ-1:4] == '0); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata)); // R6
  AST_NO_HIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |-> !hit); // R8
endmodule

bind pci_mem_bar pci_mem_bar_props #(.SZ(SZ), .PREFETCH(PREFETCH)) u_props (
  .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
  .dec_en(dec_en), .hit(hit)
);

// File: tb/sim_pci_mem_bar.sv
`timescale 1ns/1ps
module sim_pci_mem_bar;
  localparam int SZ = 16;
  localparam logic [31:0] UMASK = ~((32'd1 << SZ) - 1);
  localparam logic [31:0] TYPEV = 32'h8;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_rd = 0, dec_en = 0;
  logic [31:0] cfg_wdata = 0, bus_addr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_rdata;
  logic hit;

  int checks = 0, fails = 0;
  logic [31:0] m_base = 0, m_rd = TYPEV;
  logic done = 0;

  always #2.5 clk = ~clk;

  pci_mem_bar #(.SZ(SZ), .PREFETCH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_be(cfg_be), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .bus_addr(bus_addr), .dec_en(dec_en), .hit(hit)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr, bit rd, logic [31:0] wd, logic [3:0] be,
                      bit de, logic [31:0] addr);
    @(negedge clk);
    cfg_wr = wr; cfg_rd = rd; cfg_wdata = wd; cfg_be = be;
    dec_en = de; bus_addr = addr;
    @(posedge clk);
    if (rd) m_rd = m_base | TYPEV;
    if (wr)
      for (int k = 0; k < 4; k++)
        if (be[k])
          for (int b = 8*k; b < 8*k+8; b++)
            if (UMASK[b]) m_base[b] = wd[b];
    #1;
    check({tag, " rdata"}, cfg_rdata, m_rd);
    check({tag, " hit"}, {31'd0, hit},
          {31'd0, de && ((addr & UMASK) == m_base)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdata", cfg_rdata, TYPEV);
    @(negedge clk); rst_n = 1;
    step("R1 first read", 0, 1, 0, 0, 1, 32'h0000_1234);
    step("R3 size write", 1, 0, 32'hFFFF_FFFF, 4'hF, 0, 0);
    step("R3 size read", 0, 1, 0, 0, 1, 32'hFFFF_0004);
    step("R6 hold", 0, 0, 0, 0, 0, 0);
    step("R4 upper write", 1, 0, 32'h1234_5678, 4'b1100, 0, 0);
    step("R4 read", 0, 1, 0, 0, 1, 32'h1234_ABCD);
    step("R5 lane2 write", 1, 0, 32'hFFAB_FFFF, 4'b0100, 0, 0);
    step("R5 read", 0, 1, 0, 0, 1, 32'h12AB_0010);
    step("R5 lane0/1 write", 1, 0, 32'hFFFF_FFFF, 4'b0011, 1, 32'h12AB_FFFF);
    step("R2 read", 0, 1, 0, 0, 0, 32'h12AB_0000);
    step("R7 miss", 0, 0, 0, 0, 1, 32'h12AC_0000);
    step("R7 hit top", 0, 0, 0, 0, 1, 32'h12AB_FFFF);
    step("R8 disabled", 0, 0, 0, 0, 0, 32'h12AB_0000);
    step("R9 rd+wr", 1, 1, 32'hA5A5_000F, 4'hF, 1, 32'hA5A5_0000);
    step("R9 after", 0, 1, 0, 0, 1, 32'hA5A5_8000);
    step("R7 new window", 0, 0, 0, 0, 1, 32'h12AB_0000);
    for (int i = 0; i < 20; i++)
      step("R4 sweep", i % 2 == 0, i % 3 == 0, 32'h0101_0101 * i,
           4'(i), i % 4 != 0, 32'h0001_0000 * i);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule